// File: doc/BRIEF.md
# Memory Parity Guard and Lockout

The block sits between an 8-bit CPU data bus and three memory regions: main memory, character memory and control memory. Each region is held as a word array in which a ninth bit carries even parity. Every CPU write stores the byte with a parity bit that makes the 9-bit word even. Every CPU read checks the stored word and returns the byte one cycle later. A control-memory write also checks the word it is about to overwrite. A self-test input can store the inverted parity bit on purpose.

A parity failure sets a sticky status flag. Unless override is on, it also latches a lockout. From the cycle in which the bad data would have appeared, the lockout drives the CPU read bus to all zeros, which the CPU decodes as endless no-operation instructions. During lockout the block also blanks and freezes the character display port and ignores all further CPU accesses. Only a restart pulse, a diagnostic-access pulse or the asynchronous reset releases it. With override on, a failure does not lock. Instead it raises a sticky underline-all flag for the display.

Top module: `mem_parity_guard`

## Requirements
- R1: A write stores the byte together with a parity bit that makes the 9-bit word even. A read of a clean word returns the byte on `rdata_o` with `rvalid_o` high in the cycle after the request.
- R2: `region_i` selects main (2'b00), character (2'b01) or control (2'b10). The code 2'b11 makes no memory access and no parity check: `rvalid_o` stays low and `rdata_o` stays zero.
- R3: A word with odd parity found by a check sets `status_o` one cycle after the result cycle. The flag stays set until an `err_clr_i` pulse, a restart, a diagnostic access or reset clears it. A new error in the same cycle wins over the clear.
- R4: A control-memory write checks the parity of the word it overwrites and treats a failure exactly like a read failure. The new word is written either way.
- R5: A failure with `override_i` low raises `lockout_o` and forces `rdata_o` to zero in the result cycle itself. Both then hold until release.
- R6: While `lockout_o` is high, CPU requests are ignored: nothing is written, and no read returns `rvalid_o`.
- R7: `disp_rd_i` reads character memory at `disp_addr_i`, and `disp_char_o` shows the byte from the next cycle on and holds it. During lockout `disp_char_o` is zero and the display read register is not updated.
- R8: A one-cycle pulse on `restart_i` or `diag_i` clears lockout, status and underline at the next clock edge. A low `rst_ni` clears them at once.
- R9: With `override_i` high, a failure returns the stored byte, does not lock, and sets the sticky `underline_o` one cycle after the result cycle.
- R10: With `force_bad_i` high, a write stores the inverted parity bit, so that the next check of that word fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| restart_i | input | 1 | Restart command pulse, releases lockout |
| diag_i | input | 1 | Diagnostic access pulse, releases lockout |
| cpu_req_i | input | 1 | CPU access request |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| region_i | input | 2 | Region select: 00 main, 01 character, 10 control, 11 none |
| addr_i | input | AW | Word address within the region |
| wdata_i | input | 8 | Write byte |
| force_bad_i | input | 1 | Store inverted parity on this write |
| override_i | input | 1 | Parity override: report by underline instead of lockout |
| err_clr_i | input | 1 | Write-one-to-clear pulse for the status flag |
| rdata_o | output | 8 | Read byte, zero when idle or locked |
| rvalid_o | output | 1 | Read result valid |
| lockout_o | output | 1 | Lockout active |
| status_o | output | 1 | Sticky parity-error status |
| underline_o | output | 1 | Underline-all request under override |
| disp_rd_i | input | 1 | Display read strobe into character memory |
| disp_addr_i | input | AW | Display read address |
| disp_char_o | output | 8 | Display character byte, zero during lockout |

## Verification
The bench goes after the result cycle of a bad read. A design that registers the lockout one cycle late would leak the erroneous byte onto the bus. A design that fails to gate accesses during lockout would let writes made while locked show up after a restart. For the control-region write check, a write-first memory would compare the new word instead of the old one and miss the seeded error. The override path must return the data and raise only the underline flag, and a status clear must leave underline set. Random traffic across all four region codes, with concurrent display reads, checks read-first ordering against a bench memory model.

// File: rtl/mpg_pkg.sv
`timescale 1ns/1ps
package mpg_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned NUM_BANKS = 3;

  typedef enum logic [1:0] {
    RGN_MAIN = 2'b00,
    RGN_CHAR = 2'b01,
    RGN_CTRL = 2'b10,
    RGN_NONE = 2'b11
  } region_e;

  // bit that makes {p, d} even
  function automatic logic even_par(input logic [DATA_W-1:0] d);
    return ^d;
  endfunction
endpackage

// File: rtl/mpg_bank.sv
`timescale 1ns/1ps
module mpg_bank #(
  parameter int unsigned AW      = 6,
  parameter int unsigned DW      = 8,
  parameter bit          DISP_EN = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_re_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW:0]   cpu_wword_i,
  output logic [DW:0]   cpu_rword_o,
  input  logic          disp_re_i,
  input  logic [AW-1:0] disp_addr_i,
  output logic [DW-1:0] disp_rword_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (cpu_we_i) mem_q[cpu_addr_i] <= cpu_wword_i;
  end

  // read-first: a write in the same cycle returns the old word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cpu_rword_o <= '0;
    else if (cpu_re_i) cpu_rword_o <= mem_q[cpu_addr_i];
  end

  logic [DW:0] disp_word;
  assign disp_word = mem_q[disp_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        disp_rword_o <= '0;
    else if (disp_re_i) disp_rword_o <= DISP_EN ? disp_word[DW-1:0] : '0;
  end
endmodule

// File: rtl/mpg_lock.sv
`timescale 1ns/1ps
module mpg_lock #(
  parameter int unsigned DW = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        soft_rst_i,
  input  logic        chk_i,
  input  logic [DW:0] word_i,
  input  logic        override_i,
  input  logic        clr_i,
  output logic        err_o,
  output logic        lockout_o,
  output logic        status_o,
  output logic        underline_o
);
  logic lock_q, stat_q, ul_q;
  logic set_lock;

  assign err_o     = chk_i & (^word_i);
  assign set_lock  = err_o & ~override_i;
  assign lockout_o = lock_q | set_lock;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      stat_q <= 1'b0;
      ul_q   <= 1'b0;
    end else if (soft_rst_i) begin
      lock_q <= 1'b0;
      stat_q <= 1'b0;
      ul_q   <= 1'b0;
    end else begin
      lock_q <= lock_q | set_lock;
      stat_q <= (stat_q & ~clr_i) | err_o;
      ul_q   <= ul_q | (err_o & override_i);
    end
  end

  assign status_o    = stat_q;
  assign underline_o = ul_q;
endmodule

// File: rtl/mpg_disp.sv
`timescale 1ns/1ps
module mpg_disp #(
  parameter int unsigned DW = 8
) (
  input  logic          disp_rd_i,
  input  logic          lockout_i,
  input  logic [DW-1:0] word_i,
  output logic          disp_re_o,
  output logic [DW-1:0] char_o
);
  // receivers off and output buffer cleared while locked
  assign disp_re_o = disp_rd_i & ~lockout_i;
  assign char_o    = lockout_i ? '0 : word_i;
endmodule

// File: rtl/mem_parity_guard.sv
`timescale 1ns/1ps
module mem_parity_guard
  import mpg_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              diag_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [1:0]        region_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              force_bad_i,
  input  logic              override_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              lockout_o,
  output logic              status_o,
  output logic              underline_o,
  input  logic              disp_rd_i,
  input  logic [AW-1:0]     disp_addr_i,
  output logic [DATA_W-1:0] disp_char_o
);
  localparam int unsigned DW = DATA_W;

  logic          soft_rst;
  logic          acc_v, chk_d, rd_d;
  logic          chk_q, rd_q;
  logic [1:0]    rgn_q;
  logic [DW:0]   wword;
  logic [DW:0]   bank_rword [NUM_BANKS];
  logic [DW-1:0] bank_disp  [NUM_BANKS];
  logic [DW:0]   rword_m;
  logic [DW-1:0] disp_any;
  logic          disp_re;
  logic          err_now;

  assign soft_rst = restart_i | diag_i;
  assign wword    = {even_par(wdata_i) ^ force_bad_i, wdata_i};

  assign acc_v = cpu_req_i & (region_i != RGN_NONE) & ~lockout_o;
  assign chk_d = acc_v & (~cpu_we_i | (region_i == RGN_CTRL));
  assign rd_d  = acc_v & ~cpu_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_q <= 1'b0;
      rd_q  <= 1'b0;
      rgn_q <= RGN_NONE;
    end else begin
      chk_q <= chk_d;
      rd_q  <= rd_d;
      if (acc_v) rgn_q <= region_i;
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic sel;
    assign sel = (region_i == 2'(g));
    mpg_bank #(
      .AW      (AW),
      .DW      (DW),
      .DISP_EN (g == int'(RGN_CHAR))
    ) u_bank (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .cpu_re_i     (chk_d & sel),
      .cpu_we_i     (acc_v & cpu_we_i & sel),
      .cpu_addr_i   (addr_i),
      .cpu_wword_i  (wword),
      .cpu_rword_o  (bank_rword[g]),
      .disp_re_i    (disp_re),
      .disp_addr_i  (disp_addr_i),
      .disp_rword_o (bank_disp[g])
    );
  end

  always_comb begin
    rword_m  = '0;
    disp_any = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (rgn_q == 2'(i)) rword_m = bank_rword[i];
      disp_any = disp_any | bank_disp[i];
    end
  end

  mpg_lock #(.DW(DW)) u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst),
    .chk_i       (chk_q),
    .word_i      (rword_m),
    .override_i  (override_i),
    .clr_i       (err_clr_i),
    .err_o       (err_now),
    .lockout_o   (lockout_o),
    .status_o    (status_o),
    .underline_o (underline_o)
  );

  mpg_disp #(.DW(DW)) u_disp (
    .disp_rd_i (disp_rd_i),
    .lockout_i (lockout_o),
    .word_i    (disp_any),
    .disp_re_o (disp_re),
    .char_o    (disp_char_o)
  );

  assign rvalid_o = rd_q;
  assign rdata_o  = (rd_q & ~lockout_o) ? rword_m[DW-1:0] : '0;
endmodule

// File: rtl/mpg_sva.sv
`timescale 1ns/1ps
module mpg_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       restart_i,
  input logic       diag_i,
  input logic       cpu_req_i,
  input logic       cpu_we_i,
  input logic [1:0] region_i,
  input logic       override_i,
  input logic       err_clr_i,
  input logic [7:0] rdata_o,
  input logic       rvalid_o,
  input logic       lockout_o,
  input logic       status_o,
  input logic       underline_o,
  input logic [7:0] disp_char_o,
  input logic       err_now
);
  a_r5_zero_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_o |-> rdata_o == 8'h00);

  a_r5_lock_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lockout_o) && !$past(restart_i || diag_i) |-> lockout_o);

  a_r6_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(cpu_req_i && !cpu_we_i && region_i != 2'b11 && !lockout_o));

  a_r7_disp_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_o |-> disp_char_o == 8'h00);

  a_r3_status_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_now && !restart_i && !diag_i |=> status_o);

  a_r3_status_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(status_o) && !$past(err_clr_i || restart_i || diag_i) |-> status_o);

  a_r9_no_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_now && override_i && !$past(lockout_o) |-> !lockout_o);

  a_r9_underline: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_now && override_i && !restart_i && !diag_i |=> underline_o);

  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i || diag_i |=> !status_o && !underline_o);
endmodule

bind mem_parity_guard mpg_sva u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .restart_i   (restart_i),
  .diag_i      (diag_i),
  .cpu_req_i   (cpu_req_i),
  .cpu_we_i    (cpu_we_i),
  .region_i    (region_i),
  .override_i  (override_i),
  .err_clr_i   (err_clr_i),
  .rdata_o     (rdata_o),
  .rvalid_o    (rvalid_o),
  .lockout_o   (lockout_o),
  .status_o    (status_o),
  .underline_o (underline_o),
  .disp_char_o (disp_char_o),
  .err_now     (err_now)
);

// File: tb/mem_parity_guard_test.sv
`timescale 1ns/1ps
module mem_parity_guard_test;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 0, diag = 0, req = 0, we = 0, force_bad = 0, override = 0, err_clr = 0;
  logic [1:0] region = 2'b11;
  logic [AW-1:0] addr = '0, disp_addr = '0;
  logic [7:0] wdata = '0;
  logic disp_rd = 0;
  logic [7:0] rdata, disp_char;
  logic rvalid, lockout, status, underline;

  int n_chk = 0, n_fail = 0;

  logic [8:0] m_mem [3][DEPTH];
  bit m_lock = 0, m_stat = 0, m_ul = 0;
  logic [7:0] m_disp = '0;

  always #2 clk = ~clk;

  mem_parity_guard #(.AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .diag_i(diag),
    .cpu_req_i(req), .cpu_we_i(we), .region_i(region), .addr_i(addr),
    .wdata_i(wdata), .force_bad_i(force_bad), .override_i(override),
    .err_clr_i(err_clr), .rdata_o(rdata), .rvalid_o(rvalid),
    .lockout_o(lockout), .status_o(status), .underline_o(underline),
    .disp_rd_i(disp_rd), .disp_addr_i(disp_addr), .disp_char_o(disp_char)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // bench model of one access, then drive it and check the result cycle
  task automatic op(input logic [1:0] rg, input bit w, input logic [AW-1:0] a,
                    input logic [7:0] d, input bit bad, input bit drd,
                    input logic [AW-1:0] da, input string tag);
    logic [8:0] word;
    bit acc, err, exp_rv;
    logic [7:0] exp_rd;
    word = '0;
    err = 0;
    acc = (rg != 2'b11) && !m_lock;
    if (acc) begin
      word = m_mem[rg][a];
      err = (!w || rg == 2'b10) && (^word);
    end
    if (drd && !m_lock) m_disp = m_mem[1][da][7:0];
    if (acc && w) m_mem[rg][a] = {(^d) ^ bad, d};
    if (err && !override) m_lock = 1;
    if (err) m_stat = 1;
    if (err && override) m_ul = 1;
    exp_rv = acc && !w;
    exp_rd = (exp_rv && !m_lock) ? word[7:0] : 8'h00;

    req = 1; we = w; region = rg; addr = a; wdata = d; force_bad = bad;
    disp_rd = drd; disp_addr = da;
    @(negedge clk);
    req = 0; we = 0; force_bad = 0; disp_rd = 0;
    chk({tag, " rvalid"}, rvalid, exp_rv);
    chk({tag, " rdata"}, rdata, exp_rd);
    chk({tag, " lockout"}, lockout, m_lock);
    chk({tag, " disp"}, disp_char, m_lock ? 8'h00 : m_disp);
  endtask

  task automatic idle_flags(input string tag);
    @(negedge clk);
    chk({tag, " status"}, status, m_stat);
    chk({tag, " underline"}, underline, m_ul);
    chk({tag, " lockout"}, lockout, m_lock);
  endtask

  task automatic pulse_release(input bit use_diag);
    if (use_diag) diag = 1; else restart = 1;
    @(negedge clk);
    diag = 0; restart = 0;
    m_lock = 0; m_stat = 0; m_ul = 0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'h1d5e));
    for (int r = 0; r < 3; r++)
      for (int i = 0; i < DEPTH; i++) m_mem[r][i] = '0;

    #9;
    // R8: reset state
    chk("R8 reset rdata", rdata, 8'h00);
    chk("R8 reset rvalid", rvalid, 1'b0);
    chk("R8 reset lockout", lockout, 1'b0);
    chk("R8 reset status", status, 1'b0);
    chk("R8 reset underline", underline, 1'b0);
    chk("R8 reset disp", disp_char, 8'h00);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // fill every word with clean data (R1)
    for (int r = 0; r < 3; r++)
      for (int i = 0; i < DEPTH; i++)
        op(2'(r), 1'b1, AW'(i), 8'($urandom), 1'b0, 1'b0, '0, "R1 fill");

    // random clean traffic over all region codes, with display reads (R1 R2 R7)
    for (int n = 0; n < 400; n++) begin
      override = 1'($urandom);
      op(2'($urandom_range(0, 3)), 1'($urandom), AW'($urandom), 8'($urandom), 1'b0,
         1'($urandom), AW'($urandom), "R1/R2/R7 rand");
    end
    override = 0;
    idle_flags("R1 clean traffic");

    // R2: region 11 read returns nothing
    op(2'b11, 1'b0, 6'd3, 8'h00, 1'b0, 1'b0, '0, "R2 none");

    // R10 + R5: forced bad write, read back locks in the result cycle
    op(2'b00, 1'b1, 6'd5, 8'hA5, 1'b1, 1'b0, '0, "R10 bad write");
    op(2'b01, 1'b0, 6'd7, 8'h00, 1'b0, 1'b1, 6'd7, "R7 disp before lock");
    op(2'b00, 1'b0, 6'd5, 8'h00, 1'b0, 1'b0, '0, "R5 bad read");
    idle_flags("R3/R5 after error");
    // R6: accesses while locked are ignored
    op(2'b00, 1'b1, 6'd6, 8'h3C, 1'b0, 1'b1, 6'd8, "R6 locked write");
    op(2'b00, 1'b0, 6'd6, 8'h00, 1'b0, 1'b0, '0, "R6 locked read");
    idle_flags("R5 lock holds");
    pulse_release(1'b0);
    chk("R8 restart lockout", lockout, 1'b0);
    chk("R8 restart status", status, 1'b0);
    chk("R7 disp after release", disp_char, m_disp);
    op(2'b00, 1'b0, 6'd6, 8'h00, 1'b0, 1'b0, '0, "R6 old value kept");
    op(2'b00, 1'b1, 6'd5, 8'h11, 1'b0, 1'b0, '0, "R1 repair");

    // R9 + R3: override reports by underline; clear leaves underline
    override = 1;
    op(2'b01, 1'b1, 6'd3, 8'h77, 1'b1, 1'b0, '0, "R10 bad char");
    op(2'b01, 1'b0, 6'd3, 8'h00, 1'b0, 1'b0, '0, "R9 override read");
    idle_flags("R9 underline set");
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;
    m_stat = 0;
    chk("R3 clear status", status, 1'b0);
    chk("R9 underline kept", underline, 1'b1);
    pulse_release(1'b1);
    chk("R8 diag underline", underline, 1'b0);
    override = 0;
    op(2'b01, 1'b1, 6'd3, 8'h42, 1'b0, 1'b0, '0, "R1 repair char");

    // R4: control write checks the overwritten word
    op(2'b10, 1'b1, 6'd9, 8'h0F, 1'b1, 1'b0, '0, "R10 bad ctrl");
    op(2'b10, 1'b1, 6'd9, 8'hF1, 1'b0, 1'b0, '0, "R4 ctrl write check");
    idle_flags("R4 flags");
    pulse_release(1'b0);
    op(2'b10, 1'b0, 6'd9, 8'h00, 1'b0, 1'b0, '0, "R4 new word written");
    idle_flags("R4 clean after");

    // R8: async reset releases a lockout
    op(2'b00, 1'b1, 6'd1, 8'h80, 1'b1, 1'b0, '0, "R10 bad main");
    op(2'b00, 1'b0, 6'd1, 8'h00, 1'b0, 1'b0, '0, "R5 lock again");
    rst_n = 0;
    #1;
    chk("R8 async lockout", lockout, 1'b0);
    chk("R8 async status", status, 1'b0);
    m_lock = 0; m_stat = 0; m_ul = 0; m_disp = '0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    op(2'b00, 1'b1, 6'd1, 8'h81, 1'b0, 1'b0, '0, "R1 repair main");
    op(2'b00, 1'b0, 6'd1, 8'h00, 1'b0, 1'b0, '0, "R1 read after reset");

    report();
  end
endmodule